// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is the register and counting core of a real-time clock. An external one-second tick advances two 32-bit counters in opposite directions: an up-counter of elapsed seconds and a down-counter that software keeps at the complement of the up-count. Two alarm registers are compared with the up-counter. A compare hit sets a latched status bit, and that bit can drive an interrupt line and an on-switch output.

Software reaches everything through a simple 32-bit register bus with select, write, word address and data. Reads are combinational. A control register holds the alarm enables, the on-switch routing, a counter stop bit, a force bit for the on-switch output and a one-shot soft reset. The status register is cleared by writing ones. A 32-bit key register lets firmware mark that the clock has already been set up, and its value survives a soft reset.

Top module: `secondsRtc`

## Requirements
- R1: After hardware reset both counters read 0, both alarm registers read 0xFFFFFFFF, control, status and key read 0, and `irq` and `onSwitch` are low.
- R2: Word offsets are: up-count 0x00, down-count 0x04, alarm 0 at 0x08, alarm 1 at 0x0C, control 0x10, status 0x14, key 0x18. Any other offset, or an offset whose two low bits are not zero, reads as 0. `busRdata` is 0 unless `busSel` is high and `busWrite` is low.
- R3: On a cycle with `tick` high and control bit 6 clear, the up-counter adds 1 and the down-counter subtracts 1. Both wrap modulo 2^32.
- R4: While control bit 6 is set, `tick` leaves both counters unchanged. A bus write to either counter is taken in any mode, and it wins over a tick in the same cycle; the other counter still follows its tick.
- R5: On a cycle with `tick` high where the up-count equals alarm register i, status bit i (alarm 0 is bit 0, alarm 1 is bit 1) is set after that edge. This happens on every such tick, even while the counters are stopped. The bit stays set until it is cleared.
- R6: Writing to status clears each bit written as 1 and leaves the bits written as 0. A set condition in the same cycle wins over the clear.
- R7: `irq` is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1).
- R8: `onSwitch` is high when control bit 7 is set, or when control bit 2 and status bit 0 are both set, or when control bit 3 and status bit 1 are both set. While that holds, status bit 2 is set on each clock.
- R9: Writing control with bit 4 set zeroes both counters and all status bits in that cycle. Bit 4 is not stored and reads as 0. The other control bits take the written value, and the alarm registers are kept.
- R10: The key register reads back any 32-bit value written to it, and a soft reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hardware reset |
| tick | input | 1 | One-second advance strobe, one clock wide |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irq | output | 1 | Alarm interrupt |
| onSwitch | output | 1 | Power-on request output |

## Verification
The bound checker watches, on every cycle, that the counters step in opposite directions on a running tick and freeze on a stopped one. It also checks that an equal compare on a tick latches the alarm status, that a latched bit survives every cycle without a bus write, that `irq` stays low with no alarm status, and that misaligned reads return zero. The bench scenarios cover what depends on register contents over a sequence of accesses. These are the offsets, write-one-to-clear with set winning over clear, a counter write beating a tick, repeat firing while stopped, the forced on-switch, and the soft reset that spares the key and the alarm registers.

// File: rtl/secondsRtcPkg.sv
package secondsRtcPkg;
  localparam int DataW    = 32;
  localparam int AddrW    = 8;
  localparam int NumMatch = 2;
  localparam int StatW    = NumMatch + 1;
  localparam int OnSwStat = NumMatch;

  // register offsets
  localparam logic [AddrW-1:0] OffsUp        = AddrW'(8'h00);
  localparam logic [AddrW-1:0] OffsDown      = AddrW'(8'h04);
  localparam logic [AddrW-1:0] OffsMatchBase = AddrW'(8'h08);
  localparam logic [AddrW-1:0] OffsCtrl      = AddrW'(8'h10);
  localparam logic [AddrW-1:0] OffsStat      = AddrW'(8'h14);
  localparam logic [AddrW-1:0] OffsKey       = AddrW'(8'h18);

  // control bit layout
  localparam int CtlMatchEnLsb = 0;
  localparam int CtlOnSwLsb    = NumMatch;
  localparam int CtlSoftRst    = 4;
  localparam int CtlStop       = 6;
  localparam int CtlForce      = 7;

  typedef struct packed {
    logic [NumMatch-1:0] matchEn;
    logic [NumMatch-1:0] onSwMatch;
    logic                stop;
    logic                forceOn;
  } rtcCfg_t;

  typedef struct packed {
    logic                wrUp;
    logic                wrDown;
    logic [NumMatch-1:0] wrMatch;
    logic                softReset;
    logic [StatW-1:0]    clrStatus;
    logic [DataW-1:0]    wdata;
  } rtcStrobe_t;
endpackage

// File: rtl/secondsRtcCtrl.sv
module secondsRtcCtrl
  import secondsRtcPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [AddrW-1:0]              busAddr,
  input  logic [DataW-1:0]              busWdata,
  input  logic [DataW-1:0]              upCount,
  input  logic [DataW-1:0]              downCount,
  input  logic [NumMatch-1:0][DataW-1:0] matchVals,
  input  logic [StatW-1:0]              statusBits,
  output rtcStrobe_t                    strobe,
  output rtcCfg_t                       cfg,
  output logic [DataW-1:0]              busRdata
);
  logic wrEn, rdEn;
  logic hitUp, hitDown, hitCtrl, hitStat, hitKey;
  logic [NumMatch-1:0] hitMatch;
  logic [DataW-1:0] keyReg;
  logic [DataW-1:0] ctrlWord;

  assign wrEn    = busSel & busWrite;
  assign rdEn    = busSel & ~busWrite;
  assign hitUp   = (busAddr == OffsUp);
  assign hitDown = (busAddr == OffsDown);
  assign hitCtrl = (busAddr == OffsCtrl);
  assign hitStat = (busAddr == OffsStat);
  assign hitKey  = (busAddr == OffsKey);

  for (genvar i = 0; i < NumMatch; i++) begin : g_matchDecode
    assign hitMatch[i] = (busAddr == OffsMatchBase + AddrW'(4 * i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      keyReg <= '0;
    end else if (wrEn) begin
      if (hitCtrl) begin
        cfg.matchEn   <= busWdata[CtlMatchEnLsb +: NumMatch];
        cfg.onSwMatch <= busWdata[CtlOnSwLsb +: NumMatch];
        cfg.stop      <= busWdata[CtlStop];
        cfg.forceOn   <= busWdata[CtlForce];
      end
      if (hitKey) keyReg <= busWdata;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.wdata     = busWdata;
    strobe.wrUp      = wrEn & hitUp;
    strobe.wrDown    = wrEn & hitDown;
    strobe.wrMatch   = wrEn ? hitMatch : '0;
    strobe.softReset = wrEn & hitCtrl & busWdata[CtlSoftRst];
    strobe.clrStatus = (wrEn & hitStat) ? busWdata[StatW-1:0] : '0;
  end

  always_comb begin
    ctrlWord                              = '0;
    ctrlWord[CtlMatchEnLsb +: NumMatch]   = cfg.matchEn;
    ctrlWord[CtlOnSwLsb +: NumMatch]      = cfg.onSwMatch;
    ctrlWord[CtlStop]                     = cfg.stop;
    ctrlWord[CtlForce]                    = cfg.forceOn;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      if (hitUp)   busRdata = upCount;
      if (hitDown) busRdata = downCount;
      if (hitCtrl) busRdata = ctrlWord;
      if (hitStat) busRdata = DataW'(statusBits);
      if (hitKey)  busRdata = keyReg;
      for (int i = 0; i < NumMatch; i++) begin
        if (hitMatch[i]) busRdata = matchVals[i];
      end
    end
  end
endmodule

// File: rtl/secondsRtcDatapath.sv
module secondsRtcDatapath
  import secondsRtcPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tick,
  input  rtcStrobe_t                     strobe,
  input  rtcCfg_t                        cfg,
  output logic [DataW-1:0]               upCount,
  output logic [DataW-1:0]               downCount,
  output logic [NumMatch-1:0][DataW-1:0] matchVals,
  output logic [StatW-1:0]               statusBits,
  output logic                           irq,
  output logic                           onSwitch
);
  logic advance;
  logic [NumMatch-1:0] matchHit;
  logic onSwCond;
  logic [StatW-1:0] setVec;

  assign advance = tick & ~cfg.stop;

  always_ff @(posedge clk) begin
    if (!rstN)                upCount <= '0;
    else if (strobe.softReset) upCount <= '0;
    else if (strobe.wrUp)     upCount <= strobe.wdata;
    else if (advance)         upCount <= upCount + DataW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 downCount <= '0;
    else if (strobe.softReset) downCount <= '0;
    else if (strobe.wrDown)    downCount <= strobe.wdata;
    else if (advance)          downCount <= downCount - DataW'(1);
  end

  for (genvar i = 0; i < NumMatch; i++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rstN)                  matchVals[i] <= '1;
      else if (strobe.wrMatch[i]) matchVals[i] <= strobe.wdata;
    end
    assign matchHit[i] = tick & (upCount == matchVals[i]);
  end

  assign onSwCond = cfg.forceOn | (|(cfg.onSwMatch & statusBits[NumMatch-1:0]));
  assign setVec   = {onSwCond, matchHit};

  always_ff @(posedge clk) begin
    if (!rstN)                 statusBits <= '0;
    else if (strobe.softReset) statusBits <= '0;
    else                       statusBits <= setVec | (statusBits & ~strobe.clrStatus);
  end

  assign irq      = |(cfg.matchEn & statusBits[NumMatch-1:0]);
  assign onSwitch = onSwCond;
endmodule

// File: rtl/secondsRtc.sv
module secondsRtc
  import secondsRtcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic             irq,
  output logic             onSwitch
);
  rtcStrobe_t strobe;
  rtcCfg_t    cfg;
  logic [DataW-1:0] upCount, downCount;
  logic [NumMatch-1:0][DataW-1:0] matchVals;
  logic [StatW-1:0] statusBits;

  secondsRtcCtrl ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .upCount(upCount),
    .downCount(downCount), .matchVals(matchVals), .statusBits(statusBits),
    .strobe(strobe), .cfg(cfg), .busRdata(busRdata)
  );

  secondsRtcDatapath dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe), .cfg(cfg),
    .upCount(upCount), .downCount(downCount), .matchVals(matchVals),
    .statusBits(statusBits), .irq(irq), .onSwitch(onSwitch)
  );
endmodule

// File: rtl/secondsRtcChecker.sv
module secondsRtcChecker
  import secondsRtcPkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           tick,
  input logic                           busSel,
  input logic                           busWrite,
  input logic [AddrW-1:0]               busAddr,
  input logic [DataW-1:0]               busRdata,
  input logic                           irq,
  input logic [DataW-1:0]               upCount,
  input logic [DataW-1:0]               downCount,
  input logic [NumMatch-1:0][DataW-1:0] matchVals,
  input logic [StatW-1:0]               statusBits,
  input rtcCfg_t                        cfg
);
  logic busWr;
  assign busWr = busSel & busWrite;

  // R3
  counting_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick && !cfg.stop && !busWr |=>
      (upCount == $past(upCount) + DataW'(1)) && (downCount == $past(downCount) - DataW'(1)));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.stop && !busWr |=> $stable(upCount) && $stable(downCount));

  // R5
  match0_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick && (upCount == matchVals[0]) && !busWr |=> statusBits[0]);

  // R5
  match1_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick && (upCount == matchVals[1]) && !busWr |=> statusBits[1]);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[0] && !busWr |=> statusBits[0]);

  // R7
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[NumMatch-1:0] == '0) |-> !irq);

  // R2
  misaligned_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && (busAddr[1:0] != 2'b00) |-> busRdata == '0);
endmodule

bind secondsRtc secondsRtcChecker chk (
  .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .irq(irq), .upCount(upCount),
  .downCount(downCount), .matchVals(matchVals), .statusBits(statusBits), .cfg(cfg)
);

// File: tb/secondsRtc_test.sv
`timescale 1ns/1ps
module secondsRtc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, onSwitch;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 onSwitch
    logic [31:0] exp;
    string       req;
    string       what;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  secondsRtc uut (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .onSwitch(onSwitch)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = busRdata;
        1:       act = {31'b0, irq};
        default: act = {31'b0, onSwitch};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic readExp(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a;
    it.kind = 0; it.exp = e; it.req = req; it.what = $sformatf("read @%h", a);
    sb.push_back(it);
    #2;
    busSel = 0;
  endtask

  task automatic pinsExp(input logic eIrq, input logic eOn, input string req);
    item_t it;
    @(posedge clk); #1;
    it.kind = 1; it.exp = {31'b0, eIrq}; it.req = req; it.what = "irq";
    sb.push_back(it);
    it.kind = 2; it.exp = {31'b0, eOn}; it.what = "onSwitch";
    sb.push_back(it);
    #2;
  endtask

  task automatic pulseTick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; tick = 1;
      @(posedge clk); #1; tick = 0;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset values
    readExp(8'h00, 32'h0, "R1");
    readExp(8'h04, 32'h0, "R1");
    readExp(8'h08, 32'hFFFF_FFFF, "R1");
    readExp(8'h0C, 32'hFFFF_FFFF, "R1");
    readExp(8'h10, 32'h0, "R1");
    readExp(8'h14, 32'h0, "R1");
    readExp(8'h18, 32'h0, "R1");
    pinsExp(1'b0, 1'b0, "R1");

    // R2 unmapped and misaligned
    readExp(8'h1C, 32'h0, "R2");
    readExp(8'h09, 32'h0, "R2");

    // R3 counting
    pulseTick(3);
    readExp(8'h00, 32'd3, "R3");
    readExp(8'h04, 32'hFFFF_FFFD, "R3");

    // R4 stop, direct writes, write beats tick
    writeReg(8'h10, 32'h40);
    pulseTick(2);
    readExp(8'h00, 32'd3, "R4");
    writeReg(8'h00, 32'd100);
    writeReg(8'h04, 32'hFFFF_FF9B);
    readExp(8'h00, 32'd100, "R4");
    readExp(8'h04, 32'hFFFF_FF9B, "R4");
    readExp(8'h10, 32'h40, "R4");
    writeReg(8'h10, 32'h0);
    @(posedge clk); #1;
    tick = 1; busSel = 1; busWrite = 1; busAddr = 8'h00; busWdata = 32'd500;
    @(posedge clk); #1;
    tick = 0; busSel = 0; busWrite = 0;
    readExp(8'h00, 32'd500, "R4");
    readExp(8'h04, 32'hFFFF_FF9A, "R4");

    // R5 alarm 0 latching
    writeReg(8'h08, 32'd502);
    pulseTick(2);
    readExp(8'h14, 32'h0, "R5");
    pulseTick(1);
    readExp(8'h14, 32'h1, "R5");
    pinsExp(1'b0, 1'b0, "R7");
    writeReg(8'h10, 32'h01);
    pinsExp(1'b1, 1'b0, "R7");
    writeReg(8'h14, 32'h1);
    readExp(8'h14, 32'h0, "R6");
    pinsExp(1'b0, 1'b0, "R7");
    writeReg(8'h10, 32'h41);
    writeReg(8'h00, 32'd502);
    pulseTick(1);
    readExp(8'h14, 32'h1, "R5");
    pinsExp(1'b1, 1'b0, "R7");
    writeReg(8'h08, 32'hFFFF_FFFF);
    writeReg(8'h14, 32'h1);
    pulseTick(1);
    readExp(8'h14, 32'h0, "R5");
    readExp(8'h00, 32'd502, "R4");

    // R7/R8 alarm 1 and on-switch
    writeReg(8'h10, 32'h42);
    writeReg(8'h0C, 32'd502);
    pulseTick(1);
    readExp(8'h14, 32'h2, "R5");
    pinsExp(1'b1, 1'b0, "R7");
    writeReg(8'h10, 32'h4A);
    pinsExp(1'b1, 1'b1, "R8");
    readExp(8'h14, 32'h6, "R8");
    writeReg(8'h14, 32'h7);
    readExp(8'h14, 32'h4, "R6");
    pinsExp(1'b0, 1'b0, "R8");
    writeReg(8'h14, 32'h4);
    readExp(8'h14, 32'h0, "R6");
    writeReg(8'h10, 32'hC0);
    pinsExp(1'b0, 1'b1, "R8");
    readExp(8'h14, 32'h4, "R8");

    // R10 key, R9 soft reset
    writeReg(8'h18, 32'hB5C1_3F27);
    readExp(8'h18, 32'hB5C1_3F27, "R10");
    writeReg(8'h10, 32'h10);
    readExp(8'h00, 32'h0, "R9");
    readExp(8'h04, 32'h0, "R9");
    readExp(8'h14, 32'h0, "R9");
    readExp(8'h10, 32'h0, "R9");
    readExp(8'h0C, 32'd502, "R9");
    readExp(8'h18, 32'hB5C1_3F27, "R10");
    pinsExp(1'b0, 1'b0, "R9");

    // R3 wrap, R5 compare at all-ones
    writeReg(8'h00, 32'hFFFF_FFFF);
    pulseTick(1);
    readExp(8'h00, 32'h0, "R3");
    readExp(8'h04, 32'hFFFF_FFFF, "R3");
    readExp(8'h14, 32'h1, "R5");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule